// File: doc/BRIEF.md
# Serial PHY Bring-Up Sequencer

This block drives the power-on bring-up of a serial PHY through a command port that moves addresses and data over the PHY's internal register handshake. A one-cycle `start` pulse turns on the PHY's reference PLL clock enable and waits a short settling time. The sequencer then pulses the PHY reset: it addresses the clock/reset register and writes its reset bit. The write is flagged as one that the PHY will not acknowledge. After that, the sequencer polls the lane status register. Each attempt waits a delay, sends a fresh address command and then a read command, until the receive PLL reports stable or the attempt budget runs out.

A command that the port finishes with an error stops the sequence at once. The outcome is given as a one-cycle `done` pulse with a two-bit result. After a failure the PLL clock enable is released. After a success it stays on, and the success report comes only after a long final settling delay. Both delays count clock cycles and are set by parameters.

Top module: `phy_bringup_seq`

## Requirements
- R1: Out of reset, `busy`, `done`, `pll_clk_en`, `cmd_req` and `cmd_noack` are all low.
- R2: A `start` seen while idle sets `pll_clk_en` on the next cycle. The first command request then follows after exactly SHORT_DLY cycles in which `pll_clk_en` is high.
- R3: The reset step sends two commands. The first is an address command (`cmd_op`=0) carrying 0x7F3F. The second is a write command (`cmd_op`=1) carrying 0x0001, with `cmd_noack` high. `cmd_noack` is low on every other command. Each request is a one-cycle `cmd_req` pulse, and the next request waits for `cmd_done`.
- R4: Every lock-poll attempt begins SHORT_DLY idle cycles after the previous command response. It sends an address command carrying 0x2003 and then, with no gap, a read command (`cmd_op`=2).
- R5: The receive PLL counts as locked when bit 1 of `cmd_rdata` is 1. All other bits are ignored. Polling stops at the first locked read.
- R6: If MAX_TRIES reads (10 by default) all return unlocked, the sequence ends with status 2 (lock timeout), and no further commands are sent.
- R7: A `cmd_done` with `cmd_err` high on any command ends the sequence. `done` comes on the next cycle with status 1 (handshake error), and no further commands are sent.
- R8: After a locked read, `done` is raised with status 0 (ok) once LONG_DLY cycles have passed.
- R9: `done` is a single-cycle pulse. Exactly one `done` is produced per accepted start, and `busy` is low afterwards.
- R10: A `start` pulse while the sequence is busy is ignored. It does not change the command stream, the timing or the outcome.
- R11: `pll_clk_en` is low in the `done` cycle of a failed sequence and high in the `done` cycle of a successful one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin bring-up (ignored while busy) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result with done: 0 ok, 1 handshake error, 2 lock timeout |
| pll_clk_en | output | 1 | Reference PLL clock enable to the PHY |
| cmd_req | output | 1 | One-cycle command request to the command port |
| cmd_op | output | 2 | Command kind: 0 address, 1 write, 2 read |
| cmd_wdata | output | DATA_W | Address or write data for the command |
| cmd_noack | output | 1 | This write will not be acknowledged by the PHY |
| cmd_done | input | 1 | Command port finished the outstanding command |
| cmd_err | input | 1 | Qualifies cmd_done: the command failed |
| cmd_rdata | input | DATA_W | Read data, valid with cmd_done of a read |

## Verification
The bench sweeps the attempt on which lock first appears across every value from the first to beyond the budget. It crosses this with error injection on the reset address, the reset write and early poll commands, and with several response latencies. An off-by-one in the attempt counter would show up here as one read too many or too few before the lock timeout. Idle gaps are measured before every command and before `done`. A delay counter that was short or long by a cycle, or a read that waited a poll delay after its address, would change those gaps. Read data with every bit set except bit 1 catches a wrong lock-bit select. A second start injected mid-run catches a sequencer that restarts or emits an extra `done`.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLKEN_WAIT,
        S_ADDR_RST,
        S_WR_RST,
        S_POLL_DLY,
        S_ADDR_STAT,
        S_RD_STAT,
        S_FINAL_DLY,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } cmd_op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_HS_ERR  = 2'd1,
        RES_LOCK_TO = 2'd2
    } seq_result_e;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R4 / R8: an unloaded running count steps down by exactly one
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lock_eval.sv
module lock_eval #(
    parameter int DATA_W    = 16,
    parameter int LOCK_BIT  = 1,
    parameter int MAX_TRIES = 10,
    parameter int TRW       = 4
) (
    input  logic [DATA_W-1:0] rd_data,
    input  logic [TRW-1:0]    tries_done,
    output logic              locked,
    output logic              exhausted
);
    localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

    assign locked    = |(rd_data & LOCK_MASK);
    assign exhausted = (tries_done >= TRW'(MAX_TRIES));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_seq_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          SHORT_DLY = 100,
    parameter int          LONG_DLY  = 1000,
    parameter int          MAX_TRIES = 10,
    parameter int          LOCK_BIT  = 1,
    parameter logic [15:0] RST_REG   = 16'h7F3F,
    parameter logic [15:0] RST_VAL   = 16'h0001,
    parameter logic [15:0] STAT_REG  = 16'h2003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              pll_clk_en,
    output logic              cmd_req,
    output logic [1:0]        cmd_op,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_noack,
    input  logic              cmd_done,
    input  logic              cmd_err,
    input  logic [DATA_W-1:0] cmd_rdata
);
    localparam int MAXD = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
    localparam int TW   = $clog2(MAXD + 1);
    localparam int TRW  = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        seq_state_e     state;
        logic           sent;
        logic           clken;
        logic [TRW-1:0] tries;
        seq_result_e    result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          is_cmd_state;
    logic [TRW-1:0] tries_inc;
    logic          rd_locked;
    logic          rd_exhausted;

    seq_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign tries_inc = r_q.tries + 1'b1;

    lock_eval #(
        .DATA_W    (DATA_W),
        .LOCK_BIT  (LOCK_BIT),
        .MAX_TRIES (MAX_TRIES),
        .TRW       (TRW)
    ) u_lock (
        .rd_data    (cmd_rdata),
        .tries_done (tries_inc),
        .locked     (rd_locked),
        .exhausted  (rd_exhausted)
    );

    assign is_cmd_state = (r_q.state == S_ADDR_RST)  || (r_q.state == S_WR_RST) ||
                          (r_q.state == S_ADDR_STAT) || (r_q.state == S_RD_STAT);

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (is_cmd_state)
            r_d.sent = !cmd_done;
        if (is_cmd_state && cmd_done && cmd_err) begin
            r_d.state  = S_DONE;
            r_d.result = RES_HS_ERR;
            r_d.clken  = 1'b0;
        end else begin
            unique case (r_q.state)
                S_IDLE: if (start) begin
                    r_d.state  = S_CLKEN_WAIT;
                    r_d.clken  = 1'b1;
                    r_d.sent   = 1'b0;
                    r_d.tries  = '0;
                    r_d.result = RES_OK;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(SHORT_DLY - 1);
                end
                S_CLKEN_WAIT: if (tmr_zero) r_d.state = S_ADDR_RST;
                S_ADDR_RST:   if (cmd_done) r_d.state = S_WR_RST;
                S_WR_RST: if (cmd_done) begin
                    r_d.state = S_POLL_DLY;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(SHORT_DLY - 1);
                end
                S_POLL_DLY:   if (tmr_zero) r_d.state = S_ADDR_STAT;
                S_ADDR_STAT:  if (cmd_done) r_d.state = S_RD_STAT;
                S_RD_STAT: if (cmd_done) begin
                    r_d.tries = tries_inc;
                    tmr_load  = 1'b1;
                    if (rd_locked) begin
                        r_d.state = S_FINAL_DLY;
                        tmr_val   = TW'(LONG_DLY - 1);
                    end else if (rd_exhausted) begin
                        r_d.state  = S_DONE;
                        r_d.result = RES_LOCK_TO;
                        r_d.clken  = 1'b0;
                    end else begin
                        r_d.state = S_POLL_DLY;
                        tmr_val   = TW'(SHORT_DLY - 1);
                    end
                end
                S_FINAL_DLY:  if (tmr_zero) r_d.state = S_DONE;
                S_DONE:       r_d.state = S_IDLE;
                default:      r_d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= S_IDLE;
            r_q.sent   <= 1'b0;
            r_q.clken  <= 1'b0;
            r_q.tries  <= '0;
            r_q.result <= RES_OK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cmd_op    = OP_ADDR;
        cmd_wdata = '0;
        unique case (r_q.state)
            S_ADDR_RST:  cmd_wdata = DATA_W'(RST_REG);
            S_WR_RST:    begin cmd_op = OP_WRITE; cmd_wdata = DATA_W'(RST_VAL); end
            S_ADDR_STAT: cmd_wdata = DATA_W'(STAT_REG);
            S_RD_STAT:   cmd_op = OP_READ;
            default:     cmd_op = OP_ADDR;
        endcase
    end

    assign cmd_req    = is_cmd_state && !r_q.sent;
    assign cmd_noack  = cmd_req && (r_q.state == S_WR_RST);
    assign busy       = (r_q.state != S_IDLE);
    assign done       = (r_q.state == S_DONE);
    assign status     = r_q.result;
    assign pll_clk_en = r_q.clken;

    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_done) |=> !cmd_req);

    assert_clken_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> pll_clk_en);

    assert_err_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd_state && cmd_done && cmd_err) |=> (done && status == RES_HS_ERR && !cmd_req));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_fail_clk_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != RES_OK) |-> !pll_clk_en);

    assert_try_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tries <= TRW'(MAX_TRIES));

endmodule

// File: tb/sim_phy_bringup_seq.sv
module sim_phy_bringup_seq;
    localparam int SHORT = 4;
    localparam int LONG  = 40;
    localparam int MAXT  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, pll_clk_en, cmd_req, cmd_noack;
    logic [1:0]  status, cmd_op;
    logic [15:0] cmd_wdata;
    logic        cmd_done = 1'b0;
    logic        cmd_err = 1'b0;
    logic [15:0] cmd_rdata = 16'h0000;

    always #4 clk = ~clk;

    phy_bringup_seq #(
        .DATA_W(16), .SHORT_DLY(SHORT), .LONG_DLY(LONG), .MAX_TRIES(MAXT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .status(status), .pll_clk_en(pll_clk_en), .cmd_req(cmd_req),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_noack(cmd_noack),
        .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // scenario
    int lock_at = 1;
    int err_at  = 1000;
    int lat     = 0;

    // command port model state
    int idx = 0, reads = 0, gap = 0, lat_cnt = 0, cur_op = 0;
    bit m_busy = 0, prev_done = 0;
    int done_cnt = 0, done_gap = 0, done_status = 0;
    bit done_pll = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cmd_done = 1'b0;
            cmd_err  = 1'b0;
            if (done) begin
                done_cnt++;
                done_gap    = gap;
                done_status = int'(status);
                done_pll    = pll_clk_en;
                chk(!prev_done, "R9 done longer than one cycle", 2, 1);
            end
            prev_done = done;
            if (m_busy) begin
                chk(!cmd_req, "R3 request while command outstanding", int'(cmd_req), 0);
                if (lat_cnt == 0) begin
                    cmd_done = 1'b1;
                    cmd_err  = (idx == err_at);
                    if (cur_op == 2) begin
                        reads++;
                        // R5: only bit 1 signals lock; all other bits set when unlocked
                        cmd_rdata = (reads >= lock_at) ? 16'h0002 : 16'hFFFD;
                    end
                    idx++;
                    m_busy = 0;
                    gap = 0;
                end else begin
                    lat_cnt--;
                end
            end else if (cmd_req) begin
                if (idx == 0) begin
                    chk(cmd_op == 2'd0 && cmd_wdata == 16'h7F3F, "R3 reset address cmd", int'(cmd_wdata), 'h7F3F);
                    chk(!cmd_noack, "R3 noack on address", int'(cmd_noack), 0);
                    // start is raised just after a posedge, one extra idle negedge precedes its sampling
                    chk(gap == SHORT + 1, "R2 clock-enable settle", gap, SHORT + 1);
                end else if (idx == 1) begin
                    chk(cmd_op == 2'd1 && cmd_wdata == 16'h0001, "R3 reset write cmd", int'(cmd_wdata), 1);
                    chk(cmd_noack, "R3 noack on reset write", int'(cmd_noack), 1);
                    chk(gap == 0, "R3 write follows address", gap, 0);
                end else if (idx % 2 == 0) begin
                    chk(cmd_op == 2'd0 && cmd_wdata == 16'h2003, "R4 status address cmd", int'(cmd_wdata), 'h2003);
                    chk(!cmd_noack, "R3 noack on poll address", int'(cmd_noack), 0);
                    chk(gap == SHORT, "R4 poll delay", gap, SHORT);
                end else begin
                    chk(cmd_op == 2'd2, "R4 status read cmd", int'(cmd_op), 2);
                    chk(!cmd_noack, "R3 noack on read", int'(cmd_noack), 0);
                    chk(gap == 0, "R4 read follows address", gap, 0);
                end
                chk(pll_clk_en, "R2 clock enable during commands", int'(pll_clk_en), 1);
                cur_op  = int'(cmd_op);
                m_busy  = 1;
                lat_cnt = lat;
            end else begin
                gap++;
            end
        end
    end

    task automatic run(input int l_at, input int e_at, input int lt, input bit inject);
        int d0, nom, exp_cmds, exp_st, exp_gap, wd;
        bit exp_pll;
        @(posedge clk);
        #2;
        lock_at = l_at; err_at = e_at; lat = lt;
        idx = 0; reads = 0; gap = 0;
        d0 = done_cnt;
        start = 1'b1;
        @(posedge clk);
        #2 start = 1'b0;
        if (inject) begin
            repeat (SHORT + 3) @(posedge clk);
            #2 start = 1'b1;
            @(posedge clk);
            #2 start = 1'b0;
        end
        wd = 0;
        while (done_cnt == d0 && wd < 3000) begin
            @(posedge clk);
            wd++;
        end
        chk(done_cnt > d0, "R9 done reached", done_cnt - d0, 1);
        repeat (LONG + 10) @(posedge clk);
        nom = (l_at <= MAXT) ? 2 + 2 * l_at : 2 + 2 * MAXT;
        if (e_at < nom) begin
            exp_cmds = e_at + 1; exp_st = 1; exp_pll = 0; exp_gap = 0;
        end else if (l_at <= MAXT) begin
            exp_cmds = nom; exp_st = 0; exp_pll = 1; exp_gap = LONG;
        end else begin
            exp_cmds = nom; exp_st = 2; exp_pll = 0; exp_gap = 0;
        end
        chk(done_cnt == d0 + 1, "R10 exactly one done per start", done_cnt - d0, 1);
        chk(idx == exp_cmds, (exp_st == 1) ? "R7 commands before abort" :
                             (exp_st == 2) ? "R6 commands before lock timeout" : "R5 commands until lock",
            idx, exp_cmds);
        chk(done_status == exp_st, (exp_st == 1) ? "R7 status" : (exp_st == 2) ? "R6 status" : "R8 status",
            done_status, exp_st);
        chk(done_gap == exp_gap, "R8 final delay / R7 immediate done", done_gap, exp_gap);
        chk(done_pll == exp_pll, "R11 clock enable at done", int'(done_pll), int'(exp_pll));
        chk(!busy, "R9 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(!busy && !done && !pll_clk_en && !cmd_req && !cmd_noack, "R1 reset outputs",
            int'({busy, done, pll_clk_en, cmd_req, cmd_noack}), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        chk(!busy && !pll_clk_en, "R1 idle after reset release", int'({busy, pll_clk_en}), 0);
        for (int lt = 0; lt < 3; lt++) begin
            for (int la = 1; la <= MAXT + 1; la++) begin
                for (int ek = 0; ek < 6; ek++) begin
                    int ea;
                    ea = (ek == 0) ? 1000 : (ek == 5) ? 7 : ek - 1;
                    run(la, ea, lt, (ek == 0) && (la % 3 == 0));
                end
            end
        end
        // R10: restart after success works and second start mid-run ignored
        run(MAXT, 1000, 1, 1'b1);
        run(MAXT + 1, 1000, 2, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule